// File: doc/BRIEF.md
# Handshaked Bus Cycle Master Sequencer

This block runs the master end of a bus cycle whose length is set by the responding device, not by the master. A client hands it one transfer: an address, a size code, a direction and write data. The sequencer raises the address strobe, drives the address, size and direction lines, drives write data on writes, and then raises the data strobe. It then holds the cycle open, one whole clock at a time, until the responder returns a two-bit acknowledge code or signals bus error, possibly together with halt.

Every handshake input passes through a two-flop synchronizer before the state machine sees it, so the responder may run from an unrelated clock. Read data is captured a fixed number of clocks after the acknowledge is recognized, because the acknowledge may lead valid data. After that capture, a short error window stays open so that a late bus error can still cancel the result. The outcome is reported as a one-clock status pulse: done, aborted, or retried. A retry puts the bus in a quiet hold until halt is released, and then the same transfer runs again.

Top module: `bus_cycle_master`

## Requirements
- R1: After synchronous reset, both strobes and the write-data enable are low, `rsp_status` is 0 and `req_ready` is 1.
- R2: The address strobe rises one clock before the data strobe. While the address strobe is high, `bus_addr`, `bus_size` and `bus_rd` (1 = read) hold the values of the accepted request.
- R3: On a write, `bus_wdata_oe` is high with `bus_wdata` equal to the request data from the first clock of the address strobe. The data strobe never rises in a clock where the data is not already driven.
- R4: Acknowledge, bus error and halt are recognized two clocks after they change, and the cycle is stretched one clock at a time until then. With the default parameters (latch delay 1, error window 2), an acknowledge raised in the first clock of the data strobe gives an address strobe that lasts 7 clocks, and each extra clock of acknowledge delay adds one. Every cycle lasts at least 3 clocks, counting the closing clock.
- R5: Read data is sampled one clock after the acknowledge is recognized, not in the clock of recognition. It is returned on `rsp_rdata` together with the done pulse.
- R6: Bus error without halt ends the cycle with status 2 (aborted). `rsp_rdata` and `rsp_port` keep their earlier values. If the error is raised in the first clock of the data strobe, the address strobe lasts 4 clocks.
- R7: Bus error with halt ends the cycle with status 3 (retry). Both strobes then stay low while halt is high. After halt is released, the same address, size, direction and data run again, and that run reports its own status.
- R8: A bus error that arrives after the acknowledge, within the latch delay plus error window, still aborts the cycle and no data is committed. If the error comes one clock after an immediate acknowledge, the address strobe lasts 5 clocks.
- R9: Acknowledge, bus error and halt inputs while no cycle is running produce no status and no strobe.
- R10: `rsp_status` encodes 0 = none, 1 = done, 2 = aborted, 3 = retry. It is nonzero for exactly one clock per cycle end, and only while the address strobe is low.
- R11: On a done cycle, `rsp_port` reports the acknowledge code that ended it.
- R12: `req_ready` is low for the whole of a cycle, including a retry hold. A request is taken only in a clock where `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | ADDR_W | Transfer address |
| req_size | input | 2 | Transfer size code, passed to the bus |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| bus_addr | output | ADDR_W | Address lines |
| bus_size | output | 2 | Size lines |
| bus_rd | output | 1 | Direction, 1 = read |
| bus_astb | output | 1 | Address strobe, active high |
| bus_dstb | output | 1 | Data strobe, active high |
| bus_wdata | output | DATA_W | Write data lines |
| bus_wdata_oe | output | 1 | Write data drive enable |
| bus_rdata | input | DATA_W | Read data lines |
| bus_ack | input | 2 | Acknowledge code, nonzero ends the cycle (asynchronous) |
| bus_err | input | 1 | Bus error (asynchronous) |
| bus_halt | input | 1 | Halt, combined with error requests a retry (asynchronous) |
| rsp_status | output | 2 | One-clock outcome pulse |
| rsp_rdata | output | DATA_W | Committed read data |
| rsp_port | output | 2 | Committed acknowledge code |

## Verification
The assertions check the strobe ordering, the address and size staying stable under the strobe, the rule that write data leads the data strobe, the one-clock shape of the status pulse, the quiet bus during a retry hold, and that an abort leaves the returned data untouched. These are all checked on every clock. Only the bench scenarios can show the cycle lengths, which depend on the synchronizer and wait-state timing. They also show that data is sampled one clock after acknowledge rather than at it, that a late error still cancels the result, that a retried transfer reruns with the same address and ends in its own status, and that handshake noise while idle is ignored.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    localparam int unsigned SIZE_W = 2;
    localparam int unsigned ACK_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADDR   = 3'd1,
        ST_DSTB   = 3'd2,
        ST_WAIT   = 3'd3,
        ST_LATCH  = 3'd4,
        ST_ERRWIN = 3'd5,
        ST_TERM   = 3'd6,
        ST_HOLD   = 3'd7
    } seq_state_e;

    typedef enum logic [1:0] {
        STAT_NONE  = 2'd0,
        STAT_DONE  = 2'd1,
        STAT_ABORT = 2'd2,
        STAT_RETRY = 2'd3
    } cyc_status_e;

    // Handshake inputs after synchronization
    typedef struct packed {
        logic [ACK_W-1:0] ack;
        logic             err;
        logic             halt;
    } handshake_t;

    localparam int unsigned HS_W = ACK_W + 2;

    // Error termination: halt only matters together with error
    function automatic cyc_status_e err_outcome(input logic err, input logic halt);
        if (err && halt) return STAT_RETRY;
        if (err)         return STAT_ABORT;
        return STAT_NONE;
    endfunction

    function automatic logic strobe_state(input seq_state_e s);
        return (s == ST_ADDR) || (s == ST_DSTB) || (s == ST_WAIT) ||
               (s == ST_LATCH) || (s == ST_ERRWIN);
    endfunction

endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < int'(STAGES); s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < int'(STAGES); s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bus_cycle_fsm.sv
module bus_cycle_fsm
    import bus_seq_pkg::*;
#(
    parameter int unsigned LATCH_DELAY = 1,
    parameter int unsigned ERR_WINDOW  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  handshake_t  hs,
    output seq_state_e  state,
    output logic        astb,
    output logic        dstb,
    output logic        ready,
    output logic        ack_seen,
    output logic        latch_en,
    output logic        commit,
    output cyc_status_e status
);
    localparam int unsigned CMAX = (LATCH_DELAY > ERR_WINDOW) ? LATCH_DELAY : ERR_WINDOW;
    localparam int unsigned CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] LAT_LAST = CW'(LATCH_DELAY - 1);
    localparam logic [CW-1:0] WIN_LAST = CW'(ERR_WINDOW - 1);

    seq_state_e  nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    cyc_status_e outc, outc_nxt;
    cyc_status_e err_oc;
    logic        ack_any;

    assign err_oc  = err_outcome(hs.err, hs.halt);
    assign ack_any = |hs.ack;

    always_comb begin
        nxt      = state;
        cnt_nxt  = cnt;
        outc_nxt = outc;
        ack_seen = 1'b0;
        latch_en = 1'b0;
        commit   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) nxt = ST_ADDR;
            end
            ST_ADDR: nxt = ST_DSTB;
            ST_DSTB, ST_WAIT: begin
                if (err_oc != STAT_NONE) begin
                    nxt      = ST_TERM;
                    outc_nxt = err_oc;
                end else if (ack_any) begin
                    nxt      = ST_LATCH;
                    cnt_nxt  = '0;
                    ack_seen = 1'b1;
                end else begin
                    nxt = ST_WAIT;
                end
            end
            ST_LATCH: begin
                if (err_oc != STAT_NONE) begin
                    nxt      = ST_TERM;
                    outc_nxt = err_oc;
                end else if (cnt == LAT_LAST) begin
                    latch_en = 1'b1;
                    nxt      = ST_ERRWIN;
                    cnt_nxt  = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_ERRWIN: begin
                if (err_oc != STAT_NONE) begin
                    nxt      = ST_TERM;
                    outc_nxt = err_oc;
                end else if (cnt == WIN_LAST) begin
                    nxt      = ST_TERM;
                    outc_nxt = STAT_DONE;
                    commit   = 1'b1;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_TERM: nxt = (outc == STAT_RETRY) ? ST_HOLD : ST_IDLE;
            ST_HOLD: begin
                if (!hs.halt) nxt = ST_ADDR;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            outc  <= STAT_NONE;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            outc  <= outc_nxt;
        end
    end

    assign astb   = strobe_state(state);
    assign dstb   = astb && (state != ST_ADDR);
    assign ready  = (state == ST_IDLE);
    assign status = (state == ST_TERM) ? outc : STAT_NONE;

    // R10
    status_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (status != STAT_NONE) |=> (status == STAT_NONE));

    // R10
    status_quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (status != STAT_NONE) |-> !astb);

    // R2
    dstb_under_astb_chk: assert property (@(posedge clk) disable iff (rst)
        dstb |-> astb);

    // R2
    astb_leads_dstb_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(astb) |-> !dstb);

    // R4
    min_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(astb) |=> astb);

    // R7
    retry_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && hs.halt) |=> !astb);

    // R12
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        astb |-> !ready);
endmodule

// File: rtl/bus_xfer_regs.sv
module bus_xfer_regs
    import bus_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [ACK_W-1:0]  ack_code,
    input  logic              astb,
    input  logic              dstb,
    input  logic              ack_seen,
    input  logic              latch_en,
    input  logic              commit,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [SIZE_W-1:0] bus_size,
    output logic              bus_rd,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ACK_W-1:0]  rsp_port
);
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] size_q;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] stage_rd;
    logic [ACK_W-1:0]  stage_port;

    // Request is held for the whole cycle and any retry of it
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            size_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else if (start) begin
            addr_q  <= req_addr;
            size_q  <= req_size;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
        end
    end

    // Staging: sampled during the cycle, committed only on a clean end
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_rd   <= '0;
            stage_port <= '0;
            rsp_rdata  <= '0;
            rsp_port   <= '0;
        end else begin
            if (ack_seen) stage_port <= ack_code;
            if (latch_en) stage_rd   <= bus_rdata;
            if (commit) begin
                rsp_port <= stage_port;
                if (!wr_q) rsp_rdata <= stage_rd;
            end
        end
    end

    assign bus_addr     = addr_q;
    assign bus_size     = size_q;
    assign bus_rd       = !wr_q;
    assign bus_wdata    = wdata_q;
    assign bus_wdata_oe = wr_q && astb;

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (astb && $past(astb)) |-> ($stable(bus_addr) && $stable(bus_size) && $stable(bus_rd)));

    // R3
    wdata_leads_dstb_chk: assert property (@(posedge clk) disable iff (rst)
        (dstb && !bus_rd) |-> (bus_wdata_oe && $past(bus_wdata_oe)));
endmodule

// File: rtl/bus_cycle_master.sv
module bus_cycle_master
    import bus_seq_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LATCH_DELAY = 1,
    parameter int unsigned ERR_WINDOW  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic              bus_rd,
    output logic              bus_astb,
    output logic              bus_dstb,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        bus_ack,
    input  logic              bus_err,
    input  logic              bus_halt,
    output logic [1:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [1:0]        rsp_port
);
    logic [HS_W-1:0] hs_raw, hs_sync;
    handshake_t      hs;
    seq_state_e      state;
    cyc_status_e     status;
    logic            start, ack_seen, latch_en, commit;

    assign hs_raw = {bus_ack, bus_err, bus_halt};
    assign hs     = handshake_t'(hs_sync);
    assign start  = req_valid && req_ready;

    bus_sync #(.WIDTH(HS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (hs_raw),
        .q   (hs_sync)
    );

    bus_cycle_fsm #(.LATCH_DELAY(LATCH_DELAY), .ERR_WINDOW(ERR_WINDOW)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .hs       (hs),
        .state    (state),
        .astb     (bus_astb),
        .dstb     (bus_dstb),
        .ready    (req_ready),
        .ack_seen (ack_seen),
        .latch_en (latch_en),
        .commit   (commit),
        .status   (status)
    );

    bus_xfer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .req_addr     (req_addr),
        .req_size     (req_size),
        .req_write    (req_write),
        .req_wdata    (req_wdata),
        .ack_code     (hs.ack),
        .astb         (bus_astb),
        .dstb         (bus_dstb),
        .ack_seen     (ack_seen),
        .latch_en     (latch_en),
        .commit       (commit),
        .bus_rdata    (bus_rdata),
        .bus_addr     (bus_addr),
        .bus_size     (bus_size),
        .bus_rd       (bus_rd),
        .bus_wdata    (bus_wdata),
        .bus_wdata_oe (bus_wdata_oe),
        .rsp_rdata    (rsp_rdata),
        .rsp_port     (rsp_port)
    );

    assign rsp_status = status;

    // R6
    abort_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
        (status == STAT_ABORT) |-> ($stable(rsp_rdata) && $stable(rsp_port)));

    // R8
    abort_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (status == STAT_ABORT) |-> !$past(commit));

    // R9
    idle_no_status_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !$past(bus_astb) && $past(req_ready)) |-> (status == STAT_NONE));
endmodule

// File: tb/tb_bus_cycle_master.sv
module tb_bus_cycle_master;
    localparam int AW = 32;
    localparam int DW = 32;

    typedef struct packed {
        logic          wr;
        logic [1:0]    sz;
        logic [31:0]   addr;
        logic [31:0]   wd;
        logic [31:0]   rd;
        logic [1:0]    port;
        logic [1:0]    mode;  // 0 ack, 1 error, 2 ack then late error, 3 retry then ack
        logic [3:0]    dly;
        logic [1:0]    est;
        logic [4:0]    elen;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 2'b00, 32'h0000_1000, 32'h0,          32'hA5A5_0001, 2'b11, 2'd0, 4'd0, 2'd1, 5'd7},
        '{1'b1, 2'b10, 32'h0000_2004, 32'h1234_5678, 32'h0,          2'b10, 2'd0, 4'd3, 2'd1, 5'd10},
        '{1'b0, 2'b01, 32'h0000_3001, 32'h0,          32'hC0DE_0003, 2'b01, 2'd0, 4'd5, 2'd1, 5'd12},
        '{1'b0, 2'b00, 32'h0000_4000, 32'h0,          32'hBAD0_0004, 2'b11, 2'd1, 4'd1, 2'd2, 5'd5},
        '{1'b1, 2'b00, 32'h0000_5008, 32'h8765_4321, 32'h0,          2'b11, 2'd2, 4'd0, 2'd2, 5'd5},
        '{1'b0, 2'b00, 32'h0000_600C, 32'h0,          32'h600D_0006, 2'b11, 2'd3, 4'd0, 2'd1, 5'd7},
        '{1'b1, 2'b11, 32'h0000_7010, 32'hFACE_0007, 32'h0,          2'b10, 2'd3, 4'd2, 2'd1, 5'd7},
        '{1'b0, 2'b01, 32'h0000_8003, 32'h0,          32'h0000_0088, 2'b01, 2'd0, 4'd0, 2'd1, 5'd7}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_size;
    logic          bus_rd, bus_astb, bus_dstb, bus_wdata_oe;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic [1:0]    bus_ack = '0;
    logic          bus_err = 1'b0;
    logic          bus_halt = 1'b0;
    logic [1:0]    rsp_status;
    logic [DW-1:0] rsp_rdata;
    logic [1:0]    rsp_port;

    int checks = 0;
    int errors = 0;
    bit reported = 0;
    logic [31:0] exp_rd = '0;
    logic [1:0]  exp_port = '0;

    always #5 clk = ~clk;

    bus_cycle_master dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_rd(bus_rd),
        .bus_astb(bus_astb), .bus_dstb(bus_dstb),
        .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_halt(bus_halt),
        .rsp_status(rsp_status), .rsp_rdata(rsp_rdata), .rsp_port(rsp_port)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    endtask

    task automatic run_vec(input vec_t v);
        int  slen = 0;
        int  wctr = 0;
        int  resp_at = -1;
        int  hold_ctr = -1;
        int  cur_dly;
        bit  responded = 0;
        bit  retry_pass;
        bit  saw_retry = 0;
        bit  fin = 0;
        bit  addr_bad = 0;
        bit  wr_bad = 0;
        bit  rdy_bad = 0;
        bit  hold_bad = 0;
        logic [1:0] st = 2'd0;
        cur_dly    = int'(v.dly);
        retry_pass = (v.mode == 2'd3);
        @(negedge clk);
        req_addr  = v.addr;
        req_size  = v.sz;
        req_write = v.wr;
        req_wdata = v.wd;
        req_valid = 1'b1;
        bus_rdata = 32'hDEAD_0000 ^ v.addr;
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 0; n < 80 && !fin; n++) begin
            st = rsp_status;
            if (bus_astb) begin
                slen++;
                if (bus_addr != v.addr || bus_size != v.sz || bus_rd != !v.wr) addr_bad = 1;
                if (req_ready) rdy_bad = 1;
                if (bus_dstb && v.wr && (!bus_wdata_oe || bus_wdata != v.wd)) wr_bad = 1;
            end
            if (hold_ctr >= 0 && bus_astb) hold_bad = 1;
            if (hold_ctr >= 0 && req_ready) rdy_bad = 1;
            if (st != 2'd0) begin
                if (st == 2'd3 && retry_pass) begin
                    saw_retry  = 1;
                    retry_pass = 0;
                    slen       = 0;
                    hold_ctr   = 0;
                end else begin
                    fin = 1;
                end
            end
            if (responded && !bus_astb) begin
                bus_ack = 2'b00;
                bus_err = 1'b0;
            end
            if (!fin) begin
                if (bus_dstb && !responded) begin
                    if (wctr == cur_dly) begin
                        responded = 1;
                        resp_at   = n;
                        if (retry_pass) begin
                            bus_err  = 1'b1;
                            bus_halt = 1'b1;
                        end else if (v.mode == 2'd1) begin
                            bus_err = 1'b1;
                        end else begin
                            bus_ack = v.port;
                        end
                    end else begin
                        wctr++;
                    end
                end
                if (responded && bus_astb && v.mode == 2'd2 && n == resp_at + 1) bus_err = 1'b1;
                if (responded && n == resp_at + 3) bus_rdata = v.rd;
                if (hold_ctr >= 0) begin
                    hold_ctr++;
                    if (hold_ctr == 5) begin
                        bus_halt  = 1'b0;
                        hold_ctr  = -1;
                        responded = 0;
                        wctr      = 0;
                        cur_dly   = 0;
                        bus_rdata = 32'hDEAD_0000 ^ v.addr;
                    end
                end
            end
            if (!fin) @(negedge clk);
        end
        check(fin == 1, "R4 cycle ended", {31'd0, fin}, 32'd1);
        check(st == v.est, "R10 status code", {30'd0, st}, {30'd0, v.est});
        check(slen == int'(v.elen), "R4 strobe length", slen, {27'd0, v.elen});
        check(!addr_bad, "R2 address/size/dir held", {31'd0, addr_bad}, 32'd0);
        check(!wr_bad, "R3 write data driven under data strobe", {31'd0, wr_bad}, 32'd0);
        check(!rdy_bad, "R12 ready low while busy", {31'd0, rdy_bad}, 32'd0);
        if (v.mode == 2'd3) begin
            check(saw_retry, "R7 retry status before rerun", {31'd0, saw_retry}, 32'd1);
            check(!hold_bad, "R7 bus quiet during halt", {31'd0, hold_bad}, 32'd0);
        end
        if (st == 2'd1) begin
            exp_port = v.port;
            if (!v.wr) exp_rd = v.rd;
        end
        if (v.mode == 2'd2)
            check(rsp_rdata == exp_rd, "R8 late error commits nothing", rsp_rdata, exp_rd);
        else if (v.est == 2'd2)
            check(rsp_rdata == exp_rd && rsp_port == exp_port, "R6 abort keeps result", rsp_rdata, exp_rd);
        else
            check(rsp_rdata == exp_rd, "R5 read data sampled after ack", rsp_rdata, exp_rd);
        check(rsp_port == exp_port, "R11 port code", {30'd0, rsp_port}, {30'd0, exp_port});
        @(negedge clk);
        check(rsp_status == 2'd0, "R10 status one clock", {30'd0, rsp_status}, 32'd0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!bus_astb && !bus_dstb && !bus_wdata_oe, "R1 strobes low after reset",
              {29'd0, bus_astb, bus_dstb, bus_wdata_oe}, 32'd0);
        check(rsp_status == 2'd0, "R1 status idle", {30'd0, rsp_status}, 32'd0);
        check(req_ready == 1'b1, "R1 ready after reset", {31'd0, req_ready}, 32'd1);

        for (int i = 0; i < NV; i++) run_vec(TBL[i]);

        // R9 handshake noise while idle
        begin
            bit noisy = 0;
            bus_ack = 2'b11;
            bus_err = 1'b1;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (rsp_status != 2'd0 || bus_astb) noisy = 1;
                if (k == 2) bus_halt = 1'b1;
            end
            bus_ack  = 2'b00;
            bus_err  = 1'b0;
            bus_halt = 1'b0;
            repeat (4) @(negedge clk);
            if (rsp_status != 2'd0 || bus_astb) noisy = 1;
            check(!noisy, "R9 idle ignores handshake", {31'd0, noisy}, 32'd0);
            check(rsp_rdata == exp_rd, "R9 idle leaves result", rsp_rdata, exp_rd);
        end

        // R12 request held with ready sampled: one cycle only per acceptance
        run_vec(TBL[0]);

        // R1 reset mid-cycle returns to idle
        @(negedge clk);
        req_addr  = 32'h0000_9000;
        req_write = 1'b1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!bus_astb && !bus_dstb && req_ready, "R1 reset aborts cycle",
              {29'd0, bus_astb, bus_dstb, req_ready}, 32'd1);
        check(rsp_rdata == 32'd0, "R1 result cleared", rsp_rdata, 32'd0);

        summary();
    end
endmodule